// File: doc/BRIEF.md
# Write Cycle Qualifier with Supply Lockout

This block sits between the raw bus control pins of a memory device and its command register. Each clock it samples the active-low chip enable, write enable and output enable. It decides whether a real write cycle has happened. A write counts only when chip enable and write enable are both low and output enable is high. That condition must hold for a minimum number of consecutive samples, so short noise pulses on either enable are thrown away.

When a qualified interval ends cleanly, the block emits a single-cycle write strobe. The strobe carries the address and data that were present on the last sample of the interval. An ending is clean when chip enable or write enable rises while output enable is still high and the supply is good. A supply-low flag, the digital stand-in for an analog detector, blocks every write while it is high. It also holds the downstream command and program/erase state in reset. Decoding of the command sequences is left to the consumer of the strobe.

Top module: `wr_qualify`

## Requirements
- R1: A write is accepted only after `ce_n_i`=0, `we_n_i`=0, `oe_n_i`=1 and `vlow_i`=0 hold together for at least `MIN_W` consecutive clock samples. `wr_stb_o` rises on the clock after the first sample in which `ce_n_i` or `we_n_i` is 1 while `oe_n_i`=1 and `vlow_i`=0.
- R2: While `oe_n_i`=0, no write interval counts. If `oe_n_i` falls during an interval, even one that is already long enough, the interval is dropped with no strobe.
- R3: A low pulse shorter than `MIN_W` samples, on `we_n_i` or on `ce_n_i`, gives no strobe. It also leaves `cmd_addr_o` and `cmd_data_o` unchanged.
- R4: Each qualified interval gives exactly one strobe, one clock wide, however long the interval lasts.
- R5: `cmd_addr_o` and `cmd_data_o` show the `addr_i` and `data_i` of the final sample of the accepted interval. They change in the same cycle the strobe is high and hold until the next accepted write.
- R6: While `vlow_i`=1 no strobe is produced. If `vlow_i` rises during an interval, the interval is cancelled.
- R7: `cmd_rst_o` is 1 during `rst_n`=0. After reset it equals `vlow_i` delayed by one clock, so every rise of `vlow_i` gives at least one cycle of `cmd_rst_o`=1.
- R8: An enable that stays low while `vlow_i` falls needs a full `MIN_W` new samples after the fall before it can qualify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n_i | input | 1 | Chip enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| vlow_i | input | 1 | Supply-low flag, 1 = supply below write threshold |
| addr_i | input | AW | Bus address |
| data_i | input | DW | Bus write data |
| wr_stb_o | output | 1 | One-cycle strobe of a qualified write |
| cmd_addr_o | output | AW | Address of the last accepted write |
| cmd_data_o | output | DW | Data of the last accepted write |
| cmd_rst_o | output | 1 | Reset to command and program/erase state |

## Verification
The hardest cases from the ports are the overlaps. One is a write interval that is already long enough but is then aborted by output enable or by the supply flag. Another is an enable held low across a supply-low release, which must start its count again from zero. Directed tasks build each case by holding the enables low across a timed change of `oe_n_i` or `vlow_i`. They count strobes and compare the command outputs before and after.

// File: rtl/wq_pkg.sv
package wq_pkg;
  // Saturating increment of the width counter.
  function automatic int unsigned wq_sat_inc(int unsigned cur, int unsigned lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction

  // Pin pattern that marks a write-enabled sample (active-low pins).
  function automatic logic wq_write_pins(logic ce_n, logic we_n, logic oe_n);
    return (!ce_n) && (!we_n) && oe_n;
  endfunction
endpackage

// File: rtl/wq_inhibit.sv
module wq_inhibit (
  input  logic ce_n_i,
  input  logic we_n_i,
  input  logic oe_n_i,
  input  logic lock_i,
  output logic term_o,
  output logic clean_end_o
);
  import wq_pkg::*;

  // Active write sample: pins right and supply good.
  assign term_o      = wq_write_pins(ce_n_i, we_n_i, oe_n_i) && !lock_i;
  // Interval may close here: an enable released, read side idle, supply good.
  assign clean_end_o = (ce_n_i || we_n_i) && oe_n_i && !lock_i;
endmodule

// File: rtl/wq_width_filter.sv
module wq_width_filter #(
  parameter int unsigned MIN_W = 4,
  localparam int unsigned CW   = $clog2(MIN_W + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic term_i,
  input  logic clean_end_i,
  output logic accept_o,
  output logic fire_o
);
  import wq_pkg::*;

  localparam logic [CW-1:0] LIM = CW'(MIN_W);

  logic [CW-1:0] cnt_q;
  logic          long_enough;

  assign long_enough = (cnt_q == LIM);
  assign accept_o    = long_enough && clean_end_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fire_o <= 1'b0;
    end else begin
      cnt_q  <= term_i ? CW'(wq_sat_inc(int'(cnt_q), MIN_W)) : '0;
      fire_o <= accept_o;
    end
  end

  // R1
  count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);
  // R1
  fire_after_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> (!$past(term_i) && $past(term_i, 2)));
  // R4
  fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);
endmodule

// File: rtl/wq_lockout.sv
module wq_lockout (
  input  logic clk,
  input  logic rst_n,
  input  logic vlow_i,
  output logic lock_o,
  output logic lock_entry_o,
  output logic cmd_rst_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) cmd_rst_o <= 1'b1;
    else        cmd_rst_o <= vlow_i;
  end

  assign lock_o       = vlow_i;
  assign lock_entry_o = vlow_i && !cmd_rst_o;

  // R7
  entry_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_entry_o |=> cmd_rst_o);
endmodule

// File: rtl/wr_qualify.sv
module wr_qualify #(
  parameter int unsigned AW    = 19,
  parameter int unsigned DW    = 8,
  parameter int unsigned MIN_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n_i,
  input  logic          we_n_i,
  input  logic          oe_n_i,
  input  logic          vlow_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          wr_stb_o,
  output logic [AW-1:0] cmd_addr_o,
  output logic [DW-1:0] cmd_data_o,
  output logic          cmd_rst_o
);
  logic lock, lock_entry, term, clean_end, accept;
  logic [AW-1:0] hold_addr_q;
  logic [DW-1:0] hold_data_q;

  wq_lockout u_lock (
    .clk(clk), .rst_n(rst_n), .vlow_i(vlow_i),
    .lock_o(lock), .lock_entry_o(lock_entry), .cmd_rst_o(cmd_rst_o)
  );

  wq_inhibit u_inh (
    .ce_n_i(ce_n_i), .we_n_i(we_n_i), .oe_n_i(oe_n_i), .lock_i(lock),
    .term_o(term), .clean_end_o(clean_end)
  );

  wq_width_filter #(.MIN_W(MIN_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .term_i(term), .clean_end_i(clean_end),
    .accept_o(accept), .fire_o(wr_stb_o)
  );

  // Track the bus during the interval; publish only on acceptance.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_addr_q <= '0;
      hold_data_q <= '0;
      cmd_addr_o  <= '0;
      cmd_data_o  <= '0;
    end else begin
      if (term) begin
        hold_addr_q <= addr_i;
        hold_data_q <= data_i;
      end
      if (accept) begin
        cmd_addr_o <= hold_addr_q;
        cmd_data_o <= hold_data_q;
      end
    end
  end

  // R2
  stb_needs_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> $past(oe_n_i));
  // R6
  stb_not_in_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> !cmd_rst_o);
  // R5
  cmd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb_o |-> ($stable(cmd_addr_o) && $stable(cmd_data_o)));
endmodule

// File: tb/wr_qualify_bench.sv
module wr_qualify_bench;
  localparam int AW = 19, DW = 8, MIN_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, vlow = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic wr_stb, cmd_rst;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;

  int checks = 0, fails = 0, stb_cnt = 0, cyc = 0;

  always #4 clk = ~clk;

  wr_qualify #(.AW(AW), .DW(DW), .MIN_W(MIN_W)) u_wr_qualify (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n), .we_n_i(we_n), .oe_n_i(oe_n),
    .vlow_i(vlow), .addr_i(addr), .data_i(data), .wr_stb_o(wr_stb),
    .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data), .cmd_rst_o(cmd_rst)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && wr_stb) stb_cnt <= stb_cnt + 1;
  end

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Low interval of len samples; use_ce selects which enable pulses.
  task automatic pulse(int len, bit use_ce, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    addr = a; data = d;
    if (use_ce) begin we_n = 1'b0; ce_n = 1'b0; end
    else        begin ce_n = 1'b0; we_n = 1'b0; end
    idle(len);
    if (use_ce) ce_n = 1'b1; else we_n = 1'b1;
    idle(3);
    ce_n = 1'b1; we_n = 1'b1;
    idle(1);
  endtask

  task automatic t_reset;
    chk("R7 cmd_rst in reset", cmd_rst, 1);
    chk("R4 no strobe in reset", wr_stb, 0);
    rst_n = 1'b1;
    idle(2);
    chk("R7 cmd_rst after reset", cmd_rst, 0);
  endtask

  task automatic t_good;
    int s0 = stb_cnt;
    @(negedge clk);
    ce_n = 0; we_n = 0; addr = 19'h1_0AAA; data = 8'h11;
    idle(3);
    addr = 19'h0_5555; data = 8'hA5;
    idle(1);
    we_n = 1;
    @(negedge clk);
    chk("R1 strobe one cycle after release", wr_stb, 1);
    chk("R5 addr from final sample", cmd_addr, 19'h0_5555);
    chk("R5 data from final sample", cmd_data, 8'hA5);
    @(negedge clk);
    chk("R4 strobe one cycle wide", wr_stb, 0);
    ce_n = 1; idle(2);
    chk("R1 one strobe count", stb_cnt - s0, 1);
  endtask

  task automatic t_short;
    int s0 = stb_cnt;
    pulse(MIN_W - 1, 0, 19'h7_0001, 8'h01);
    chk("R3 short we pulse no strobe", stb_cnt - s0, 0);
    chk("R3 addr kept", cmd_addr, 19'h0_5555);
    pulse(MIN_W - 1, 1, 19'h7_0002, 8'h02);
    chk("R3 short ce pulse no strobe", stb_cnt - s0, 0);
    chk("R3 data kept", cmd_data, 8'hA5);
    pulse(MIN_W, 1, 19'h0_2AAA, 8'h55);
    chk("R1 ce pulse at min width", stb_cnt - s0, 1);
    chk("R5 ce write addr", cmd_addr, 19'h0_2AAA);
  endtask

  task automatic t_long;
    int s0 = stb_cnt;
    pulse(25, 0, 19'h1_2345, 8'h3C);
    chk("R4 long pulse single strobe", stb_cnt - s0, 1);
    chk("R5 long pulse data", cmd_data, 8'h3C);
  endtask

  task automatic t_oe;
    int s0 = stb_cnt;
    oe_n = 0;
    pulse(8, 0, 19'h0_0F0F, 8'hEE);
    oe_n = 1;
    chk("R2 oe low blocks write", stb_cnt - s0, 0);
    @(negedge clk);
    ce_n = 0; we_n = 0; addr = 19'h0_1111; data = 8'h77;
    idle(MIN_W + 2);
    oe_n = 0; idle(1);
    we_n = 1; ce_n = 1; idle(1);
    oe_n = 1; idle(3);
    chk("R2 oe fall aborts interval", stb_cnt - s0, 0);
    chk("R2 cmd data kept", cmd_data, 8'h3C);
  endtask

  task automatic t_lock;
    int s0 = stb_cnt;
    @(negedge clk);
    vlow = 1;
    @(negedge clk);
    chk("R7 cmd_rst follows vlow", cmd_rst, 1);
    pulse(8, 0, 19'h0_4444, 8'h44);
    chk("R6 no write while locked", stb_cnt - s0, 0);
    vlow = 0; @(negedge clk);
    chk("R7 cmd_rst released", cmd_rst, 0);
    // vlow rises inside a qualified interval
    ce_n = 0; we_n = 0; addr = 19'h0_6666; data = 8'h66;
    idle(MIN_W + 1);
    vlow = 1; idle(1);
    we_n = 1; idle(1);
    vlow = 0; ce_n = 1; idle(3);
    chk("R6 vlow cancels interval", stb_cnt - s0, 0);
    chk("R6 cmd addr kept", cmd_addr, 19'h1_2345);
  endtask

  task automatic t_recount;
    int s0 = stb_cnt;
    @(negedge clk);
    vlow = 1; ce_n = 0; we_n = 0; addr = 19'h0_0101; data = 8'h9A;
    idle(6);
    vlow = 0; idle(MIN_W - 1);
    we_n = 1; idle(3); ce_n = 1; idle(1);
    chk("R8 too few samples after release", stb_cnt - s0, 0);
    @(negedge clk);
    vlow = 1; ce_n = 0; we_n = 0;
    idle(6);
    vlow = 0; idle(MIN_W);
    we_n = 1; idle(3); ce_n = 1; idle(1);
    chk("R8 full recount accepted", stb_cnt - s0, 1);
    chk("R8 data", cmd_data, 8'h9A);
  endtask

  initial begin
    idle(3);
    t_reset();
    t_good();
    t_short();
    t_long();
    t_oe();
    t_lock();
    t_recount();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule